// File: doc/BRIEF.md
# Watchdog timer with sleep wake-up

This block is a watchdog that runs on a clock of its own, separate from the processor clock. After each restart it counts a base interval of `BASE_TICKS` watchdog-clock cycles. An optional power-of-two prescaler stretches that interval. When the interval runs out, the block looks at whether the core is asleep. A running core gets a device reset request. A sleeping core gets only a wake-up request. Either way the active-low time-out flag drops.

The processor domain drives four inputs:
- a clear strobe, which services the watchdog;
- a sleep strobe, which marks sleep entry;
- a sleep level;
- an acknowledge strobe, which releases a held request.

Each strobe crosses into the watchdog clock through a toggle synchronizer. The sleep level passes through a flop chain. Because all counting happens on the watchdog clock, a time-out is still detected while the processor clock is stopped.

The control state machine has four states:
- `WD_OFF`: disabled.
- `WD_COUNT`: counting.
- `WD_RST_HOLD`: a reset request is held.
- `WD_WAKE_HOLD`: a wake-up request is held.

Its transitions are:
- **enable**: `WD_OFF` to `WD_COUNT` when the configuration enable is high.
- **expire-awake**: `WD_COUNT` to `WD_RST_HOLD`.
- **expire-asleep**: `WD_COUNT` to `WD_WAKE_HOLD`.
- **acknowledge**: either hold state back to `WD_COUNT`.
- **disable**: any state to `WD_OFF` whenever the configuration enable is low.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset, `reset_req` and `wake_req` are 0 and `to_n` is 1.
- R2: With `core_asleep` low, a time-out raises `reset_req` and drives `to_n` to 0. A time-out occurs `BASE_TICKS` × ratio watchdog-clock cycles after the last restart, plus a synchronizer latency of at most four cycles. No request appears before that point.
- R3: With `presc_assign` = 1 and `presc_shift` = N (0 to 7), the ratio is 2^N.
- R4: With `presc_assign` = 0, the ratio is 1 whatever the value of `presc_shift`.
- R5: A `clr_strobe` pulse zeroes both the prescaler and the period counter. Clears spaced closer than the time-out interval never produce a request.
- R6: With `core_asleep` high, a time-out raises `wake_req`, leaves `reset_req` at 0, and drives `to_n` to 0.
- R7: A `sleep_strobe` pulse zeroes both the prescaler and the period counter, exactly as a clear does.
- R8: A raised request stays asserted until a `req_ack` pulse arrives. The acknowledge drops the request, and counting restarts from zero.
- R9: `to_n` returns to 1 only on a clear or a sleep strobe. An acknowledge leaves it at 0.
- R10: While `cfg_enable` is 0, the block issues neither request, and a time-out never lowers `to_n`.
- R11: Counting and the wake-up request continue while `clk_sys` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Processor-domain clock, used for the strobes |
| clk_wdt | input | 1 | Dedicated free-running watchdog clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_enable | input | 1 | Configuration enable; 0 disables the watchdog |
| presc_assign | input | 1 | 1 gives the prescaler to the watchdog |
| presc_shift | input | 3 | Prescaler exponent N; ratio is 2^N |
| clr_strobe | input | 1 | One-cycle clear pulse (clk_sys) |
| sleep_strobe | input | 1 | One-cycle sleep-entry pulse (clk_sys) |
| core_asleep | input | 1 | Level, high while the core sleeps |
| req_ack | input | 1 | One-cycle pulse releasing a held request (clk_sys) |
| reset_req | output | 1 | Held device reset request (clk_wdt) |
| wake_req | output | 1 | Held wake-up request (clk_wdt) |
| to_n | output | 1 | Time-out flag, active low |

## Verification
The checker watches the following on every watchdog-clock edge:
- each time-out becomes exactly one kind of request, chosen by the synchronized sleep level;
- `to_n` falls on a time-out and rises on a clear or sleep strobe;
- a request holds until its acknowledge;
- a disabled block stays silent.

Only the bench scenarios can show the length of the time-out interval for each prescaler setting. They also show the restart effect of clears and sleep entries that land mid-interval, and a wake-up arriving while the processor clock is gated off.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF       = 2'd0,
        WD_COUNT     = 2'd1,
        WD_RST_HOLD  = 2'd2,
        WD_WAKE_HOLD = 2'd3
    } wdog_state_e;

endpackage

// File: rtl/wdog_pulse_xing.sv
// Single-cycle pulse transfer between unrelated clocks (toggle scheme).
module wdog_pulse_xing #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);

    logic              src_tgl;
    logic [STAGES:0]   chain;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            src_tgl <= 1'b0;
        end else if (src_pulse) begin
            src_tgl <= ~src_tgl;
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], src_tgl};
        end
    end

    // An edge between the last two flops marks one transferred event.
    assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdog_level_sync.sv
// Multi-flop synchronizer for a slowly changing level.
module wdog_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '0;
                else        ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '0;
                else        ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];

endmodule

// File: rtl/wdog_prescaler.sv
// Power-of-two divider producing one enable tick every 2^N watchdog cycles.
module wdog_prescaler #(
    parameter int MAX_SHIFT = 7,
    localparam int SHIFT_W  = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1,
    localparam int PRE_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               assign_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    generate
        if (MAX_SHIFT == 0) begin : g_none
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRE_W-1:0] pre_cnt;
            logic [PRE_W-1:0] limit;

            // limit = 2^N - 1, or 0 when the prescaler is not assigned.
            always_comb begin
                if (assign_en) limit = ~({PRE_W{1'b1}} << shift);
                else           limit = '0;
            end

            // ">=" keeps the divider safe if the ratio shrinks mid-count.
            assign tick = (pre_cnt >= limit);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (restart || tick) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + PRE_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_period_counter.sv
// Counts prescaler ticks and flags the last tick of the base interval.
module wdog_period_counter #(
    parameter int BASE_TICKS = 1000,
    localparam int CNT_W     = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1,
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic done
);

    logic [CNT_W-1:0] cnt;

    assign done = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int BASE_TICKS  = 1000,
    parameter int MAX_SHIFT   = 7,
    parameter int SYNC_STAGES = 2,
    localparam int SHIFT_W    = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1
) (
    input  logic               clk_sys,
    input  logic               clk_wdt,
    input  logic               por_n,
    input  logic               cfg_enable,
    input  logic               presc_assign,
    input  logic [SHIFT_W-1:0] presc_shift,
    input  logic               clr_strobe,
    input  logic               sleep_strobe,
    input  logic               core_asleep,
    input  logic               req_ack,
    output logic               reset_req,
    output logic               wake_req,
    output logic               to_n
);

    import wdog_pkg::*;

    wdog_state_e state_q, state_d;

    logic clr_w, sleep_w, ack_w, asleep_w;
    logic restart, tick, done, expire;
    logic reset_req_q, wake_req_q, to_n_q;

    // ---- crossings from the processor domain ----
    wdog_pulse_xing #(.STAGES(SYNC_STAGES)) u_clr_x (
        .src_clk (clk_sys),
        .dst_clk (clk_wdt),
        .rst_n   (por_n),
        .src_pulse(clr_strobe),
        .dst_pulse(clr_w)
    );

    wdog_pulse_xing #(.STAGES(SYNC_STAGES)) u_sleep_x (
        .src_clk (clk_sys),
        .dst_clk (clk_wdt),
        .rst_n   (por_n),
        .src_pulse(sleep_strobe),
        .dst_pulse(sleep_w)
    );

    wdog_pulse_xing #(.STAGES(SYNC_STAGES)) u_ack_x (
        .src_clk (clk_sys),
        .dst_clk (clk_wdt),
        .rst_n   (por_n),
        .src_pulse(req_ack),
        .dst_pulse(ack_w)
    );

    wdog_level_sync #(.STAGES(SYNC_STAGES)) u_asleep_s (
        .clk  (clk_wdt),
        .rst_n(por_n),
        .d    (core_asleep),
        .q    (asleep_w)
    );

    // ---- interval timing ----
    // Counting only runs in WD_COUNT; every other state and both strobes
    // hold the divider and the counter at zero.
    assign restart = clr_w || sleep_w || (state_q != WD_COUNT);

    wdog_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_presc (
        .clk      (clk_wdt),
        .rst_n    (por_n),
        .restart  (restart),
        .assign_en(presc_assign),
        .shift    (presc_shift),
        .tick     (tick)
    );

    wdog_period_counter #(.BASE_TICKS(BASE_TICKS)) u_period (
        .clk    (clk_wdt),
        .rst_n  (por_n),
        .restart(restart),
        .tick   (tick),
        .done   (done)
    );

    // A service strobe landing on the final tick wins over the time-out.
    assign expire = done && !restart;

    // ---- state register ----
    always_ff @(posedge clk_wdt or negedge por_n) begin
        if (!por_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // ---- next-state logic ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (cfg_enable) state_d = WD_COUNT;             // enable
            end
            WD_COUNT: begin
                if (expire) begin
                    if (asleep_w) state_d = WD_WAKE_HOLD;       // expire-asleep
                    else          state_d = WD_RST_HOLD;        // expire-awake
                end
            end
            WD_RST_HOLD, WD_WAKE_HOLD: begin
                if (ack_w) state_d = WD_COUNT;                  // acknowledge
            end
            default: state_d = WD_OFF;
        endcase
        if (!cfg_enable) state_d = WD_OFF;                      // disable
    end

    // ---- registered outputs ----
    always_ff @(posedge clk_wdt or negedge por_n) begin
        if (!por_n) begin
            reset_req_q <= 1'b0;
            wake_req_q  <= 1'b0;
            to_n_q      <= 1'b1;
        end else begin
            reset_req_q <= (state_d == WD_RST_HOLD);
            wake_req_q  <= (state_d == WD_WAKE_HOLD);
            if (clr_w || sleep_w) begin
                to_n_q <= 1'b1;
            end else if (expire) begin
                to_n_q <= 1'b0;
            end
        end
    end

    assign reset_req = reset_req_q;
    assign wake_req  = wake_req_q;
    assign to_n      = to_n_q;

endmodule

// File: rtl/wdog_core_sva.sv
module wdog_core_sva (
    input logic clk_wdt,
    input logic por_n,
    input logic cfg_enable,
    input logic clr_w,
    input logic sleep_w,
    input logic ack_w,
    input logic asleep_w,
    input logic expire,
    input logic reset_req,
    input logic wake_req,
    input logic to_n
);

    p_reset_when_awake_r2: assert property (@(posedge clk_wdt) disable iff (!por_n)
        (expire && !asleep_w && cfg_enable) |=> (reset_req && !wake_req));

    p_to_drops_r2: assert property (@(posedge clk_wdt) disable iff (!por_n)
        expire |=> !to_n);

    p_wake_when_asleep_r6: assert property (@(posedge clk_wdt) disable iff (!por_n)
        (expire && asleep_w && cfg_enable) |=> (wake_req && !reset_req));

    p_one_request_r6: assert property (@(posedge clk_wdt) disable iff (!por_n)
        !(reset_req && wake_req));

    p_hold_until_ack_r8: assert property (@(posedge clk_wdt) disable iff (!por_n)
        (reset_req && !ack_w && cfg_enable) |=> reset_req);

    p_wake_hold_r8: assert property (@(posedge clk_wdt) disable iff (!por_n)
        (wake_req && !ack_w && cfg_enable) |=> wake_req);

    p_to_restore_r9: assert property (@(posedge clk_wdt) disable iff (!por_n)
        (clr_w || sleep_w) |=> to_n);

    p_off_quiet_r10: assert property (@(posedge clk_wdt) disable iff (!por_n)
        !cfg_enable |=> (!reset_req && !wake_req));

endmodule

bind wdog_core wdog_core_sva u_sva (
    .clk_wdt   (clk_wdt),
    .por_n     (por_n),
    .cfg_enable(cfg_enable),
    .clr_w     (clr_w),
    .sleep_w   (sleep_w),
    .ack_w     (ack_w),
    .asleep_w  (asleep_w),
    .expire    (expire),
    .reset_req (reset_req),
    .wake_req  (wake_req),
    .to_n      (to_n)
);

// File: tb/tb_wdog_core.sv
`timescale 1ns/1ps
module tb_wdog_core;

    localparam int BASE = 16;

    logic       clk_sys = 1'b0;
    logic       clk_wdt = 1'b0;
    bit         sys_run = 1'b1;
    logic       por_n = 1'b0;
    logic       cfg_enable = 1'b1;
    logic       presc_assign = 1'b0;
    logic [2:0] presc_shift = 3'd0;
    logic       clr_strobe = 1'b0;
    logic       sleep_strobe = 1'b0;
    logic       core_asleep = 1'b0;
    logic       req_ack = 1'b0;
    logic       reset_req, wake_req, to_n;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    wdog_core #(.BASE_TICKS(BASE), .MAX_SHIFT(7), .SYNC_STAGES(2)) dut (
        .clk_sys     (clk_sys),
        .clk_wdt     (clk_wdt),
        .por_n       (por_n),
        .cfg_enable  (cfg_enable),
        .presc_assign(presc_assign),
        .presc_shift (presc_shift),
        .clr_strobe  (clr_strobe),
        .sleep_strobe(sleep_strobe),
        .core_asleep (core_asleep),
        .req_ack     (req_ack),
        .reset_req   (reset_req),
        .wake_req    (wake_req),
        .to_n        (to_n)
    );

    // 125 MHz processor clock, gateable to model a stopped core clock.
    always begin
        #4;
        if (sys_run) clk_sys = ~clk_sys;
    end

    // Watchdog clock, 10 MHz, edges never coincide with processor edges.
    initial begin
        #3;
        forever #50 clk_wdt = ~clk_wdt;
    end

    function automatic int unsigned period_of(bit asg, int unsigned n);
        return BASE << (asg ? n : 0);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wdt_wait(int unsigned n);
        repeat (n) @(posedge clk_wdt);
        @(negedge clk_wdt);
    endtask

    task automatic pulse_clr();
        @(negedge clk_sys) clr_strobe = 1'b1;
        @(negedge clk_sys) clr_strobe = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk_sys) sleep_strobe = 1'b1;
        @(negedge clk_sys) sleep_strobe = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk_sys) req_ack = 1'b1;
        @(negedge clk_sys) req_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    // Timing: a strobe reaches the counters about three watchdog edges
    // after it is issued, so a request appears near edge P+3.
    // The bench samples at P-1 (must be quiet) and P+6 (must be raised).
    task automatic expect_reset(string tag, int unsigned p);
        pulse_clr();
        wdt_wait(p - 1);
        check({tag, " no early request"}, reset_req, 1'b0);
        wdt_wait(7);
        check({tag, " reset_req at time-out"}, reset_req, 1'b1);
        check({tag, " wake_req stays low"}, wake_req, 1'b0);
        pulse_ack();
        wdt_wait(6);
        check({tag, " released by ack"}, reset_req, 1'b0);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);

        wdt_wait(5);
        por_n = 1'b1;
        wdt_wait(1);
        // R1: reset state
        check("R1 reset_req after por", reset_req, 1'b0);
        check("R1 wake_req after por", wake_req, 1'b0);
        check("R1 to_n after por", to_n, 1'b1);

        // R2: awake time-out with ratio 1
        pulse_clr();
        wdt_wait(period_of(0, 0) - 1);
        check("R2 quiet before interval", reset_req, 1'b0);
        wdt_wait(7);
        check("R2 reset_req raised", reset_req, 1'b1);
        check("R2 to_n low", to_n, 1'b0);
        check("R2 wake_req low", wake_req, 1'b0);

        // R8: held until acknowledged
        wdt_wait(40);
        check("R8 reset_req held", reset_req, 1'b1);
        pulse_ack();
        wdt_wait(6);
        check("R8 reset_req released", reset_req, 1'b0);
        // R9: ack does not restore to_n; clear does
        check("R9 to_n stays low after ack", to_n, 1'b0);
        pulse_clr();
        wdt_wait(6);
        check("R9 to_n restored by clear", to_n, 1'b1);

        // R3: random prescaler exponents
        presc_assign = 1'b1;
        for (int i = 0; i < 4; i++) begin
            int unsigned n;
            n = $urandom_range(5, 1);
            presc_shift = 3'(n);
            expect_reset("R3 random ratio", period_of(1, n));
        end
        // R3: largest ratio
        presc_shift = 3'd7;
        expect_reset("R3 ratio 128", period_of(1, 7));

        // R4: unassigned prescaler gives ratio 1
        presc_assign = 1'b0;
        presc_shift  = 3'd7;
        expect_reset("R4 unassigned", period_of(0, 7));

        // R5: servicing faster than the interval never trips
        presc_assign = 1'b1;
        presc_shift  = 3'd2;
        for (int i = 0; i < 6; i++) begin
            pulse_clr();
            wdt_wait($urandom_range(50, 10));
        end
        check("R5 serviced no reset", reset_req, 1'b0);
        check("R5 serviced to_n high", to_n, 1'b1);

        // R6: time-out while asleep gives wake-up only
        core_asleep = 1'b1;
        pulse_sleep();
        wdt_wait(period_of(1, 2) - 1);
        check("R6 quiet before interval", wake_req, 1'b0);
        wdt_wait(7);
        check("R6 wake_req raised", wake_req, 1'b1);
        check("R6 no reset while asleep", reset_req, 1'b0);
        check("R6 to_n low", to_n, 1'b0);
        core_asleep = 1'b0;
        pulse_ack();
        wdt_wait(6);
        check("R8 wake_req released", wake_req, 1'b0);

        // R7: sleep entry mid-interval restarts the count
        core_asleep = 1'b1;
        pulse_clr();
        wdt_wait(32);
        pulse_sleep();
        wdt_wait(40);
        check("R7 no wake at old deadline", wake_req, 1'b0);
        check("R7 no reset at old deadline", reset_req, 1'b0);
        wdt_wait(30);
        check("R7 wake at restarted deadline", wake_req, 1'b1);
        core_asleep = 1'b0;
        pulse_ack();
        wdt_wait(6);
        check("R9 to_n low after wake ack", to_n, 1'b0);
        pulse_sleep();
        wdt_wait(6);
        check("R9 to_n restored by sleep", to_n, 1'b1);

        // R11: processor clock stopped during sleep
        presc_assign = 1'b0;
        core_asleep  = 1'b1;
        pulse_sleep();
        sys_run = 1'b0;
        wdt_wait(period_of(0, 0) + 7);
        check("R11 wake with clk_sys stopped", wake_req, 1'b1);
        check("R11 to_n low with clk_sys stopped", to_n, 1'b0);
        check("R11 no reset with clk_sys stopped", reset_req, 1'b0);
        sys_run = 1'b1;
        core_asleep = 1'b0;
        pulse_ack();
        wdt_wait(6);
        check("R11 wake released after restart", wake_req, 1'b0);

        // R10: disabled block stays silent
        pulse_clr();
        @(negedge clk_sys) cfg_enable = 1'b0;
        wdt_wait(3 * BASE + 10);
        check("R10 no reset when disabled", reset_req, 1'b0);
        check("R10 no wake when disabled", wake_req, 1'b0);
        check("R10 to_n unchanged when disabled", to_n, 1'b1);

        finish_run();
    end

    initial begin
        #1_500_000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

endmodule